// File: doc/BRIEF.md
# DRAM Self-Refresh Entry Sequencer

This block moves a two-rank DRAM subsystem into self-refresh after a fault on the host link. It knows nothing about the command state the DRAMs were left in. Instead it runs one fixed recovery walk that is safe from any starting point. The walk turns off periodic refresh, locks out the normal scheduler, and waits for in-flight traffic to drain. It then raises CKE, precharges all banks, refreshes each rank and finally puts each rank into self-refresh. The refresh and self-refresh-entry commands to the two ranks are spaced by programmable gaps, so that both ranks do not draw peak current at once.

Every wait is set by a timing input counted in controller clocks. A wait state with value N lasts N+1 cycles, and a one-cycle command state follows it. The gap between two consecutive sequence events is therefore N+2 cycles. A force-low control keeps both CKE pins low and keeps every command off the bus, while the walk itself still runs. Once the sequence has parked, a link-ready indication brings both ranks back out of self-refresh automatically. This exit is skipped when the exit-disable control or the force-low control is set.

Top module: `dram_sr_seq`

## Requirements
- R1: When sync_err_i or elec_idle_i is high at a clock edge while the block is idle or parked, aref_clr_o is high for exactly the next cycle and busy_o goes high in that same cycle.
- R2: sched_block_o is high from the second cycle of the sequence until the block returns to idle. Every command appears with sched_block_o high.
- R3: With t_cke_i = N, the cycle in which cke_o becomes 2'b11 is at least N+3 cycles after the aref_clr_o cycle. It also comes no earlier than one cycle after rw_busy_i is seen low in the drain wait.
- R4: Precharge-all (cmd_o = 1, cmd_rank_o = 2'b11, where bit 0 is rank 0 and bit 1 is rank 1) is issued t_xsnr_i+2 cycles after the cycle in which CKE rose.
- R5: Refresh (cmd_o = 2) goes to rank 0 (mask 2'b01) t_rp_i+2 cycles after precharge. It goes to rank 1 (mask 2'b10) gap_ref_i+2 cycles after that. Each refresh targets exactly one rank.
- R6: Self-refresh entry (cmd_o = 3) goes to rank 0 t_rfc_i+2 cycles after the rank-1 refresh. It goes to rank 1 gap_sre_i+2 cycles later. The CKE bit of a rank drops in the cycle after its entry command.
- R7: In the cycle after the rank-1 entry command, done_o = 1, busy_o = 0, sched_block_o = 1 and cke_o = 2'b00.
- R8: While cke_force_low_i is high, cke_o = 2'b00 and cmd_valid_o = 0. The walk keeps its timing and still reaches the parked state.
- R9: A trigger that arrives while busy_o is high has no effect on the command sequence. A trigger that arrives while parked restarts the whole walk.
- R10: While parked, link_ready_i high at an edge with exit_dis_i and cke_force_low_i low produces a self-refresh exit (cmd_o = 4, mask 2'b11) in the next cycle, with cke_o = 2'b11. The block then returns to idle with sched_block_o low.
- R11: While parked, link_ready_i high at an edge with exit_dis_i or cke_force_low_i set returns the block to idle with no command issued and cke_o left at 2'b00.
- R12: During and right after reset, cke_o = 2'b00 and cmd_valid_o, sched_block_o, aref_clr_o, busy_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_err_i | input | 1 | Link sync-train error trigger |
| elec_idle_i | input | 1 | Link electrical-idle trigger |
| rw_busy_i | input | 1 | Reads or writes still in flight |
| cke_force_low_i | input | 1 | Hold CKE low and suppress all commands |
| exit_dis_i | input | 1 | Suppress automatic self-refresh exit |
| link_ready_i | input | 1 | Link in test state with core clock stable |
| t_cke_i | input | TW | Minimum CKE pulse width in clocks |
| t_xsnr_i | input | TW | Self-refresh exit to non-read command time |
| t_rp_i | input | TW | Precharge time |
| t_rfc_i | input | TW | Refresh cycle time |
| gap_ref_i | input | TW | Rank stagger for refresh commands |
| gap_sre_i | input | TW | Rank stagger for self-refresh entry commands |
| cke_o | output | 2 | Per-rank clock enable |
| cmd_valid_o | output | 1 | Command present on cmd_o |
| cmd_o | output | 3 | Command code: 1 precharge-all, 2 refresh, 3 SR entry, 4 SR exit |
| cmd_rank_o | output | 2 | Rank mask of the command |
| sched_block_o | output | 1 | Blocks the normal command scheduler |
| aref_clr_o | output | 1 | Clear strobe for the periodic refresh enable |
| busy_o | output | 1 | Entry walk in progress |
| done_o | output | 1 | Ranks parked in self-refresh |

## Verification
The properties assume that the trigger, busy, force and link inputs are driven free of X from reset onward. They also assume the timing inputs are held steady while a walk is running, because a wait counter loaded mid-walk would break the spacing relations. The stimulus changes timing values and control levels only on falling edges, and only while the block is idle or parked. Triggers and the busy release are placed on chosen cycles inside the walk, so both the ignored-trigger case and the extended drain are reached under those assumptions.

// File: rtl/dram_sr_pkg.sv
package dram_sr_pkg;

  localparam int RANKS = 2;
  localparam int CMD_W = 3;

  typedef enum logic [4:0] {
    ST_IDLE, ST_CLR, ST_BLOCK, ST_DRAIN, ST_CKEH, ST_WXSNR,
    ST_PREA, ST_WRP, ST_REF0, ST_WSTR1, ST_REF1, ST_WRFC,
    ST_SRE0, ST_WSTR2, ST_SRE1, ST_PARK, ST_SRX
  } sr_state_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_REF  = 3'd2,
    CMD_SRE  = 3'd3,
    CMD_SRX  = 3'd4
  } sr_cmd_e;

  // States that hold on the shared countdown timer.
  function automatic logic is_wait(sr_state_e s);
    return s inside {ST_DRAIN, ST_WXSNR, ST_WRP, ST_WSTR1, ST_WRFC, ST_WSTR2};
  endfunction

  // DRAM command issued while in a state.
  function automatic sr_cmd_e cmd_of(sr_state_e s);
    case (s)
      ST_PREA:         return CMD_PREA;
      ST_REF0, ST_REF1: return CMD_REF;
      ST_SRE0, ST_SRE1: return CMD_SRE;
      ST_SRX:          return CMD_SRX;
      default:         return CMD_NOP;
    endcase
  endfunction

  // Rank mask of that command: bit 0 rank 0, bit 1 rank 1.
  function automatic logic [RANKS-1:0] mask_of(sr_state_e s);
    case (s)
      ST_REF0, ST_SRE0: return 2'b01;
      ST_REF1, ST_SRE1: return 2'b10;
      ST_PREA, ST_SRX:  return 2'b11;
      default:          return 2'b00;
    endcase
  endfunction

  // Cycles between two consecutive sequence events around a wait of v.
  function automatic int unsigned event_gap(int unsigned v);
    return v + 2;
  endfunction

endpackage

// File: rtl/sr_wait_timer.sv
module sr_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import dram_sr_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          rw_busy_i,
  input  logic          force_low_i,
  input  logic          exit_dis_i,
  input  logic          link_ready_i,
  input  logic [TW-1:0] t_cke_i,
  input  logic [TW-1:0] t_xsnr_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rfc_i,
  input  logic [TW-1:0] gap_ref_i,
  input  logic [TW-1:0] gap_sre_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output sr_state_e     state_o,
  output logic          drain_exit_o,
  output logic          srx_go_o
);
  sr_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign drain_exit_o = (state_q == ST_DRAIN) && tmr_zero_i && !rw_busy_i;
  assign srx_go_o     = (state_q == ST_PARK) && !trig_i && link_ready_i &&
                        !exit_dis_i && !force_low_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (trig_i) state_d = ST_CLR;
      ST_CLR:   state_d = ST_BLOCK;
      ST_BLOCK: state_d = ST_DRAIN;
      ST_DRAIN: if (drain_exit_o) state_d = ST_CKEH;
      ST_CKEH:  state_d = ST_WXSNR;
      ST_WXSNR: if (tmr_zero_i) state_d = ST_PREA;
      ST_PREA:  state_d = ST_WRP;
      ST_WRP:   if (tmr_zero_i) state_d = ST_REF0;
      ST_REF0:  state_d = ST_WSTR1;
      ST_WSTR1: if (tmr_zero_i) state_d = ST_REF1;
      ST_REF1:  state_d = ST_WRFC;
      ST_WRFC:  if (tmr_zero_i) state_d = ST_SRE0;
      ST_SRE0:  state_d = ST_WSTR2;
      ST_WSTR2: if (tmr_zero_i) state_d = ST_SRE1;
      ST_SRE1:  state_d = ST_PARK;
      ST_PARK: begin
        if (trig_i)            state_d = ST_CLR;
        else if (srx_go_o)     state_d = ST_SRX;
        else if (link_ready_i) state_d = ST_IDLE;
      end
      ST_SRX:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Load the shared timer on entry into each wait state.
  assign tmr_load_o = (state_d != state_q) && is_wait(state_d);

  always_comb begin
    case (state_d)
      ST_DRAIN: tmr_val_o = t_cke_i;
      ST_WXSNR: tmr_val_o = t_xsnr_i;
      ST_WRP:   tmr_val_o = t_rp_i;
      ST_WSTR1: tmr_val_o = gap_ref_i;
      ST_WRFC:  tmr_val_o = t_rfc_i;
      ST_WSTR2: tmr_val_o = gap_sre_i;
      default:  tmr_val_o = '0;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/sr_cmd_out.sv
module sr_cmd_out
  import dram_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sr_state_e        state_i,
  input  logic             drain_exit_i,
  input  logic             srx_go_i,
  input  logic             force_low_i,
  output logic [RANKS-1:0] cke_o,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [RANKS-1:0] rank_o,
  output logic             block_o,
  output logic             aref_clr_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [RANKS-1:0] cke_q;
  logic             cke_raise;
  sr_cmd_e          cmd_raw;

  assign cke_raise = drain_exit_i || srx_go_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cke_q    <= '0;
    else if (cke_raise)          cke_q    <= '1;
    else if (state_i == ST_SRE0) cke_q[0] <= 1'b0;
    else if (state_i == ST_SRE1) cke_q[1] <= 1'b0;
  end

  assign cmd_raw     = force_low_i ? CMD_NOP : cmd_of(state_i);
  assign cmd_valid_o = (cmd_raw != CMD_NOP);
  assign cmd_o       = cmd_raw;
  assign rank_o      = cmd_valid_o ? mask_of(state_i) : '0;
  assign cke_o       = force_low_i ? '0 : cke_q;
  assign block_o     = !(state_i inside {ST_IDLE, ST_CLR});
  assign aref_clr_o  = (state_i == ST_CLR);
  assign done_o      = (state_i == ST_PARK);
  assign busy_o      = !(state_i inside {ST_IDLE, ST_PARK, ST_SRX});
endmodule

// File: rtl/dram_sr_seq.sv
module dram_sr_seq
  import dram_sr_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_err_i,
  input  logic          elec_idle_i,
  input  logic          rw_busy_i,
  input  logic          cke_force_low_i,
  input  logic          exit_dis_i,
  input  logic          link_ready_i,
  input  logic [TW-1:0] t_cke_i,
  input  logic [TW-1:0] t_xsnr_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rfc_i,
  input  logic [TW-1:0] gap_ref_i,
  input  logic [TW-1:0] gap_sre_i,
  output logic [1:0]    cke_o,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_o,
  output logic [1:0]    cmd_rank_o,
  output logic          sched_block_o,
  output logic          aref_clr_o,
  output logic          busy_o,
  output logic          done_o
);
  // Named internal events, visible to the bound checker.
  logic          trig;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          drain_exit;
  logic          srx_go;
  sr_state_e     seq_state;

  assign trig = sync_err_i || elec_idle_i;

  sr_wait_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sr_seq_fsm #(.TW(TW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig),
    .rw_busy_i    (rw_busy_i),
    .force_low_i  (cke_force_low_i),
    .exit_dis_i   (exit_dis_i),
    .link_ready_i (link_ready_i),
    .t_cke_i      (t_cke_i),
    .t_xsnr_i     (t_xsnr_i),
    .t_rp_i       (t_rp_i),
    .t_rfc_i      (t_rfc_i),
    .gap_ref_i    (gap_ref_i),
    .gap_sre_i    (gap_sre_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .state_o      (seq_state),
    .drain_exit_o (drain_exit),
    .srx_go_o     (srx_go)
  );

  sr_cmd_out u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (seq_state),
    .drain_exit_i (drain_exit),
    .srx_go_i     (srx_go),
    .force_low_i  (cke_force_low_i),
    .cke_o        (cke_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd_o),
    .rank_o       (cmd_rank_o),
    .block_o      (sched_block_o),
    .aref_clr_o   (aref_clr_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/dram_sr_seq_chk.sv
module dram_sr_seq_chk
  import dram_sr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rw_busy_i,
  input logic       cke_force_low_i,
  input logic       exit_dis_i,
  input logic [1:0] cke_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_o,
  input logic [1:0] cmd_rank_o,
  input logic       sched_block_o,
  input logic       aref_clr_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       drain_exit
);
  a_r1_clr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    aref_clr_o |=> (!aref_clr_o && busy_o && sched_block_o));

  a_r2_cmd_under_block: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> sched_block_o);

  a_r3_drain_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drain_exit |-> !rw_busy_i);

  a_r3_cke_up_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    drain_exit |=> (cke_force_low_i || cke_o == 2'b11));

  a_r5_ref_one_rank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == CMD_REF) |-> ($countones(cmd_rank_o) == 1));

  a_r8_force_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cke_force_low_i |-> (cke_o == 2'b00 && !cmd_valid_o));

  a_r9_busy_ends_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !aref_clr_o) |=> (busy_o || done_o));

  a_r11_exit_respects_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == CMD_SRX) |-> !exit_dis_i);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && sched_block_o));
endmodule

bind dram_sr_seq dram_sr_seq_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rw_busy_i       (rw_busy_i),
  .cke_force_low_i (cke_force_low_i),
  .exit_dis_i      (exit_dis_i),
  .cke_o           (cke_o),
  .cmd_valid_o     (cmd_valid_o),
  .cmd_o           (cmd_o),
  .cmd_rank_o      (cmd_rank_o),
  .sched_block_o   (sched_block_o),
  .aref_clr_o      (aref_clr_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .drain_exit      (drain_exit)
);

// File: tb/dram_sr_seq_test.sv
module dram_sr_seq_test;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic sync_err = 1'b0, elec_idle = 1'b0, rw_busy = 1'b0;
  logic force_low = 1'b0, exit_dis = 1'b0, link_ready = 1'b0;
  logic [TW-1:0] t_cke = '0, t_xsnr = '0, t_rp = '0, t_rfc = '0, g_ref = '0, g_sre = '0;
  logic [1:0] cke;
  logic       cmd_valid;
  logic [2:0] cmd;
  logic [1:0] rank;
  logic       block, aref_clr, busy, done;

  dram_sr_seq #(.TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .sync_err_i(sync_err), .elec_idle_i(elec_idle),
    .rw_busy_i(rw_busy), .cke_force_low_i(force_low), .exit_dis_i(exit_dis),
    .link_ready_i(link_ready), .t_cke_i(t_cke), .t_xsnr_i(t_xsnr), .t_rp_i(t_rp),
    .t_rfc_i(t_rfc), .gap_ref_i(g_ref), .gap_sre_i(g_sre), .cke_o(cke),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_rank_o(rank), .sched_block_o(block),
    .aref_clr_o(aref_clr), .busy_o(busy), .done_o(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int         at;
    logic [2:0] c;
    logic [1:0] m;
    logic [1:0] k;
    string      tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: every command on the bus must match the head of the scoreboard.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && cmd_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 R11", "unexpected command", int'(cmd), 0);
      end else begin
        e = sb.pop_front();
        check(cyc == e.at, e.tag, "command cycle", cyc, e.at);
        check(cmd == e.c, e.tag, "command code", int'(cmd), int'(e.c));
        check(rank == e.m, e.tag, "rank mask", int'(rank), int'(e.m));
        check(cke == e.k, e.tag, "cke at command", int'(cke), int'(e.k));
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  // Watchdog.
  always @(posedge clk) begin
    if (cyc == 50000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  // Driver: program timing, fire a trigger, queue the expected commands and
  // walk the sequence cycle by cycle. Cycle k after the trigger edge is seen
  // with cyc == t0 + k - 1.
  task automatic run_seq(input int tc, input int tx, input int trp, input int trfc,
                         input int gr, input int gs, input bit use_idle,
                         input int busy_rel, input int poke, input bit forced);
    int t0, ckeh, pre, r0, r1, s0, s1, last;
    t_cke = TW'(tc); t_xsnr = TW'(tx); t_rp = TW'(trp); t_rfc = TW'(trfc);
    g_ref = TW'(gr); g_sre = TW'(gs);
    force_low = forced;
    rw_busy = (busy_rel > 0);
    if (use_idle) elec_idle = 1'b1; else sync_err = 1'b1;
    @(posedge clk);
    #1;
    t0 = cyc;
    sync_err = 1'b0;
    elec_idle = 1'b0;
    ckeh = (busy_rel > 0) ? busy_rel + 1 : tc + 4;
    pre  = ckeh + tx + 2;
    r0   = pre + trp + 2;
    r1   = r0 + gr + 2;
    s0   = r1 + trfc + 2;
    s1   = s0 + gs + 2;
    if (!forced) begin
      sb.push_back('{t0 + pre - 1, 3'd1, 2'b11, 2'b11, "R4"});
      sb.push_back('{t0 + r0 - 1,  3'd2, 2'b01, 2'b11, "R5"});
      sb.push_back('{t0 + r1 - 1,  3'd2, 2'b10, 2'b11, "R5"});
      sb.push_back('{t0 + s0 - 1,  3'd3, 2'b01, 2'b11, "R6"});
      sb.push_back('{t0 + s1 - 1,  3'd3, 2'b10, 2'b10, "R6"});
    end
    last = s1 + 1;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      sync_err = (k == poke);
      if (k == 1) begin
        check(aref_clr == 1'b1, "R1", "aref_clr in first cycle", int'(aref_clr), 1);
        check(busy == 1'b1, "R1", "busy in first cycle", int'(busy), 1);
      end
      if (k == 2) begin
        check(aref_clr == 1'b0, "R1", "aref_clr second cycle", int'(aref_clr), 0);
        check(block == 1'b1, "R2", "scheduler blocked", int'(block), 1);
      end
      if (busy_rel > 0 && k == ckeh - 1)
        check(cke == 2'b00, "R3", "cke held during busy drain", int'(cke), 0);
      if (k == busy_rel) rw_busy = 1'b0;
      if (k == ckeh)
        check(cke == (forced ? 2'b00 : 2'b11), "R3", "cke raised after drain",
              int'(cke), forced ? 0 : 3);
      if (forced)
        check(cke == 2'b00 && !cmd_valid, "R8", "forced low quiet",
              int'({cke, cmd_valid}), 0);
      if (k == last) begin
        check(done == 1'b1, "R7", "done when parked", int'(done), 1);
        check(busy == 1'b0, "R7", "busy when parked", int'(busy), 0);
        check(block == 1'b1, "R7", "block when parked", int'(block), 1);
        check(cke == 2'b00, "R7", "cke when parked", int'(cke), 0);
      end
    end
    sync_err = 1'b0;
    check(sb.size() == 0, "R6", "commands left pending", sb.size(), 0);
  endtask

  task automatic do_exit(input bit expect_srx);
    @(negedge clk);
    link_ready = 1'b1;
    @(posedge clk);
    #1;
    if (expect_srx) sb.push_back('{cyc, 3'd4, 2'b11, 2'b11, "R10"});
    @(negedge clk);
    link_ready = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && block == 1'b0,
          expect_srx ? "R10" : "R11", "idle after exit step",
          int'({done, busy, block}), 0);
    check(cke == (expect_srx ? 2'b11 : 2'b00), expect_srx ? "R10" : "R11",
          "cke after exit step", int'(cke), expect_srx ? 3 : 0);
    check(sb.size() == 0, "R10", "exit command pending", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cke == 2'b00 && !cmd_valid && !block && !aref_clr && !busy && !done,
          "R12", "outputs in reset", int'({cke, cmd_valid, block, aref_clr, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cke == 2'b00 && !cmd_valid && !block && !aref_clr && !busy && !done,
          "R12", "outputs after reset", int'({cke, cmd_valid, block, aref_clr, busy, done}), 0);

    // R9: trigger poked mid-walk is ignored; R10 exit follows.
    run_seq(3, 5, 2, 7, 1, 4, 1'b0, 0, 12, 1'b0);
    do_exit(1'b1);

    // All-zero timing via electrical idle, poke during drain; R11 exit disabled.
    @(negedge clk);
    run_seq(0, 0, 0, 0, 0, 0, 1'b1, 0, 3, 1'b0);
    exit_dis = 1'b1;
    do_exit(1'b0);
    exit_dis = 1'b0;

    // R3: drain held open by outstanding traffic.
    @(negedge clk);
    run_seq(2, 1, 1, 3, 2, 0, 1'b0, 15, 0, 1'b0);

    // R9: trigger while parked restarts the walk.
    @(negedge clk);
    run_seq(1, 2, 3, 4, 5, 6, 1'b1, 0, 0, 1'b0);
    do_exit(1'b1);

    // R8: forced low, then R11 exit suppressed by force.
    @(negedge clk);
    run_seq(2, 2, 2, 2, 2, 2, 1'b0, 0, 0, 1'b1);
    do_exit(1'b0);
    force_low = 1'b0;

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule